// File: doc/BRIEF.md
# Sector Buffer Fill/Empty DMA Engine

This block owns a 256-byte sector buffer and moves bytes between it and host memory. A fill copies bytes from memory into the buffer; an empty copies bytes from the buffer out to memory. The host side supplies a word count, a 16-bit bus address and two address-extension bits. A density select tells the engine whether the active sector is 128 or 256 bytes long.

The engine first checks the requested length against the sector size. It then runs a byte-serial transfer over a simple request/acknowledge memory port. The memory can answer any request with a non-existent-memory fault. When it finishes, the engine posts an error code, two error flags and the residual word count, and pulses a done strobe. A second port gives the disk side access to the buffer while the engine is idle.

Top module: `sector_dma`

## Requirements
- R1: The word count `wc_i` is an 8-bit value, and the transfer length is 2*`wc_i` bytes. Exactly that many memory requests are issued when no fault occurs.
- R2: If 2*`wc_i` is larger than the sector size (128 bytes when `den_i`=0, 256 bytes when `den_i`=1), no memory request is issued and the buffer is left unchanged. The engine finishes with `err_code_o`=8'h98 (octal 230), `wco_o`=1, `nxm_o`=0 and `resid_o`=`wc_i`.
- R3: On a fill (`fill_i`=1) that passes the length check, all 256 buffer bytes are set to zero before the first memory request. Bytes beyond the transferred length read back as zero.
- R4: Byte i of a transfer uses memory address {`ext_i`,`addr_i`}+i, computed as an 18-bit sum, and buffer index i. Bytes go in ascending order starting at i=0.
- R5: On an empty (`fill_i`=0), each request is a write (`mem_we_o`=1) that carries buffer byte i. On a fill, each request is a read (`mem_we_o`=0), and the returned byte is stored at buffer index i.
- R6: An acknowledge with `mem_nxm_i`=1 ends the transfer with no further request. The failing byte is not stored. The engine finishes with `nxm_o`=1, `wco_o`=0, `err_code_o`=0 and `resid_o`=(2*`wc_i`-i)/2, where i is the index of the failing byte.
- R7: A transfer that completes finishes with `err_code_o`=0, `wco_o`=0, `nxm_o`=0 and `resid_o`=0.
- R8: `start_i` is taken only while `busy_o`=0. A start seen while busy has no effect. Each accepted start produces exactly one `done_o` pulse, one cycle wide, in the same cycle that `busy_o` falls.
- R9: The buffer port reads with one cycle of latency. A buffer-port write while `busy_o`=1 is ignored.
- R10: A word count of zero completes with no memory request and a success status. A fill with a zero count still clears the buffer.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o`, `wco_o` and `nxm_o` are 0, and `err_code_o` and `resid_o` are 0.
- R12: `mem_req_o` stays high, with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged, until the cycle in which `mem_ack_i` is sampled high. It then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| fill_i | input | 1 | 1 = memory to buffer, 0 = buffer to memory |
| den_i | input | 1 | Sector size select: 0 = 128 bytes, 1 = 256 bytes |
| wc_i | input | 8 | Word count |
| addr_i | input | 16 | Bus address, low part |
| ext_i | input | 2 | Address extension bits placed above `addr_i` |
| busy_o | output | 1 | Engine owns the buffer |
| done_o | output | 1 | One-cycle completion strobe |
| err_code_o | output | 8 | Completion code: 0 or 8'h98 |
| wco_o | output | 1 | Word count exceeded the sector size |
| nxm_o | output | 1 | Memory reported a non-existent address |
| resid_o | output | 8 | Words not transferred |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | 18 | Memory byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, valid with acknowledge |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_nxm_i | input | 1 | Fault flag, valid with acknowledge |
| buf_we_i | input | 1 | Buffer-port write enable, ignored while busy |
| buf_addr_i | input | 8 | Buffer-port index |
| buf_wdata_i | input | 8 | Buffer-port write byte |
| buf_rdata_o | output | 8 | Buffer-port read byte, one cycle after the index |

## Verification
A wrong byte index or address counter shows at the memory port on the very next request: the address stops equalling base plus request number, and the bench tracks this on every request. A remaining-byte counter that is off by one shows up at completion, as an extra or missing request or a wrong residual. A clear phase that is skipped or cut short leaves stale bytes in the buffer, which the readback through the buffer port finds after done. A faulty finish path shows in the same cycle as done, through the code and flags, and the one-cycle strobe is checked on the edge that follows.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CLEAR,
    ST_LOAD,
    ST_ARM,
    ST_REQ
  } sdma_state_e;

  localparam logic [7:0] CODE_OK  = 8'h00;
  localparam logic [7:0] CODE_WCO = 8'o230;

endpackage

// File: rtl/sdma_ram.sv
module sdma_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Port A (engine) and port B (idle-time access) never write together,
  // so one write process keeps the array inferable as block RAM.
  always_ff @(posedge clk) begin
    if (a_we)
      mem[a_addr] <= a_wdata;
    else if (b_we)
      mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en)
      a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/sdma_len.sv
module sdma_len #(
  parameter int WCW   = 8,
  parameter int SMALL = 128,
  parameter int BIG   = 256,
  localparam int LW   = WCW + 2
) (
  input  logic [WCW-1:0] wc,
  input  logic           den,
  output logic [LW-1:0]  len,
  output logic           ovf
);

  logic [LW-1:0] limit;

  always_comb begin
    len   = LW'({wc, 1'b0});
    limit = den ? LW'(BIG) : LW'(SMALL);
    ovf   = (len > limit);
  end

endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int WCW   = 8,
  parameter int BAW   = 16,
  parameter int XW    = 2,
  parameter int SMALL = 128,
  parameter int BIG   = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int MAW  = BAW + XW,
  localparam int LW   = WCW + 2,
  localparam int CW   = (LW > AW) ? LW : AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           fill_i,
  input  logic           den_i,
  input  logic [WCW-1:0] wc_i,
  input  logic [BAW-1:0] addr_i,
  input  logic [XW-1:0]  ext_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [7:0]     err_code_o,
  output logic           wco_o,
  output logic           nxm_o,
  output logic [WCW-1:0] resid_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ack_i,
  input  logic           mem_nxm_i,
  output logic           ram_en_o,
  output logic           ram_we_o,
  output logic [AW-1:0]  ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  input  logic [DW-1:0]  ram_rdata_i
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  sdma_state_e    st_q;
  logic           fill_q;
  logic           den_q;
  logic [WCW-1:0] wc_q;
  logic [MAW-1:0] base_q;
  logic [CW-1:0]  idx_q;
  logic [LW-1:0]  rem_q;

  logic [LW-1:0]  len_w;
  logic           ovf_w;

  logic           fin;
  logic [7:0]     fin_code;
  logic           fin_wco;
  logic           fin_nxm;
  logic [WCW-1:0] fin_res;
  logic           ack_ok;

  sdma_len #(.WCW(WCW), .SMALL(SMALL), .BIG(BIG)) len_i (
    .wc  (wc_q),
    .den (den_q),
    .len (len_w),
    .ovf (ovf_w)
  );

  assign ack_ok = (st_q == ST_REQ) && mem_ack_i && !mem_nxm_i;

  // Completion decision for every state that can end a run
  always_comb begin
    fin      = 1'b0;
    fin_code = CODE_OK;
    fin_wco  = 1'b0;
    fin_nxm  = 1'b0;
    fin_res  = '0;
    case (st_q)
      ST_CHECK: begin
        if (ovf_w) begin
          fin      = 1'b1;
          fin_code = CODE_WCO;
          fin_wco  = 1'b1;
          fin_res  = wc_q;
        end else if (!fill_q && (len_w == '0)) begin
          fin = 1'b1;
        end
      end
      ST_CLEAR: begin
        if ((idx_q[AW-1:0] == LAST_IDX) && (rem_q == '0))
          fin = 1'b1;
      end
      ST_REQ: begin
        if (mem_ack_i) begin
          if (mem_nxm_i) begin
            fin     = 1'b1;
            fin_nxm = 1'b1;
            fin_res = WCW'(rem_q >> 1);
          end else if (rem_q == LW'(1)) begin
            fin = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  // Buffer port A control
  always_comb begin
    ram_we_o    = (st_q == ST_CLEAR) || (ack_ok && fill_q);
    ram_en_o    = (st_q == ST_LOAD) || ram_we_o;
    ram_addr_o  = idx_q[AW-1:0];
    ram_wdata_o = (st_q == ST_CLEAR) ? '0 : mem_rdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      fill_q      <= 1'b0;
      den_q       <= 1'b0;
      wc_q        <= '0;
      base_q      <= '0;
      idx_q       <= '0;
      rem_q       <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_code_o  <= CODE_OK;
      wco_o       <= 1'b0;
      nxm_o       <= 1'b0;
      resid_o     <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            fill_q <= fill_i;
            den_q  <= den_i;
            wc_q   <= wc_i;
            base_q <= {ext_i, addr_i};
            busy_o <= 1'b1;
            st_q   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          idx_q <= '0;
          rem_q <= len_w;
          st_q  <= fill_q ? ST_CLEAR : ST_LOAD;
        end
        ST_CLEAR: begin
          idx_q <= idx_q + CW'(1);
          if (idx_q[AW-1:0] == LAST_IDX) begin
            idx_q <= '0;
            st_q  <= ST_ARM;
          end
        end
        ST_LOAD: begin
          st_q <= ST_ARM;
        end
        ST_ARM: begin
          mem_req_o   <= 1'b1;
          mem_we_o    <= !fill_q;
          mem_addr_o  <= base_q + MAW'(idx_q);
          mem_wdata_o <= ram_rdata_i;
          st_q        <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_ack_i) begin
            mem_req_o <= 1'b0;
            idx_q     <= idx_q + CW'(1);
            rem_q     <= rem_q - LW'(1);
            st_q      <= fill_q ? ST_ARM : ST_LOAD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (fin) begin
        st_q       <= ST_IDLE;
        busy_o     <= 1'b0;
        done_o     <= 1'b1;
        err_code_o <= fin_code;
        wco_o      <= fin_wco;
        nxm_o      <= fin_nxm;
        resid_o    <= fin_res;
      end
    end
  end

endmodule

// File: rtl/sector_dma.sv
module sector_dma #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int WCW   = 8,
  parameter int BAW   = 16,
  parameter int XW    = 2,
  parameter int SMALL = 128,
  parameter int BIG   = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int MAW  = BAW + XW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           fill_i,
  input  logic           den_i,
  input  logic [WCW-1:0] wc_i,
  input  logic [BAW-1:0] addr_i,
  input  logic [XW-1:0]  ext_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [7:0]     err_code_o,
  output logic           wco_o,
  output logic           nxm_o,
  output logic [WCW-1:0] resid_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ack_i,
  input  logic           mem_nxm_i,
  input  logic           buf_we_i,
  input  logic [AW-1:0]  buf_addr_i,
  input  logic [DW-1:0]  buf_wdata_i,
  output logic [DW-1:0]  buf_rdata_o
);

  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic          side_we;

  assign side_we = buf_we_i && !busy_o;

  sdma_seq #(
    .DEPTH(DEPTH), .DW(DW), .WCW(WCW), .BAW(BAW), .XW(XW),
    .SMALL(SMALL), .BIG(BIG)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .fill_i      (fill_i),
    .den_i       (den_i),
    .wc_i        (wc_i),
    .addr_i      (addr_i),
    .ext_i       (ext_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_code_o  (err_code_o),
    .wco_o       (wco_o),
    .nxm_o       (nxm_o),
    .resid_o     (resid_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .mem_nxm_i   (mem_nxm_i),
    .ram_en_o    (ram_en),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata)
  );

  sdma_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk     (clk),
    .a_en    (ram_en),
    .a_we    (ram_we),
    .a_addr  (ram_addr),
    .a_wdata (ram_wdata),
    .a_rdata (ram_rdata),
    .b_we    (side_we),
    .b_addr  (buf_addr_i),
    .b_wdata (buf_wdata_i),
    .b_rdata (buf_rdata_o)
  );

endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
  parameter int WCW = 8,
  parameter int MAW = 18,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [7:0]     err_code_o,
  input logic           wco_o,
  input logic           nxm_o,
  input logic [WCW-1:0] resid_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [MAW-1:0] mem_addr_o,
  input logic [DW-1:0]  mem_wdata_o,
  input logic           mem_ack_i
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && start_i) |=> (busy_o || done_o));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R12
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_ack_i) |=> !mem_req_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);

  // R2
  wco_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && wco_o) |-> (err_code_o == 8'h98 && !nxm_o));

  // R7
  ok_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wco_o && !nxm_o) |-> (err_code_o == 8'h00 && resid_o == '0));

  // R6
  nxm_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && nxm_o) |-> (err_code_o == 8'h00 && !wco_o));

endmodule

bind sector_dma sdma_chk #(.WCW(WCW), .MAW(MAW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_code_o  (err_code_o),
  .wco_o       (wco_o),
  .nxm_o       (nxm_o),
  .resid_o     (resid_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/sector_dma_tb_top.sv
`timescale 1ns/1ps
module sector_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        fill_i = 1'b0;
  logic        den_i = 1'b0;
  logic [7:0]  wc_i = '0;
  logic [15:0] addr_i = '0;
  logic [1:0]  ext_i = '0;
  logic        busy_o, done_o, wco_o, nxm_o;
  logic [7:0]  err_code_o, resid_o;
  logic        mem_req_o, mem_we_o;
  logic [17:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_nxm = 1'b0;
  logic        buf_we_i = 1'b0;
  logic [7:0]  buf_addr_i = '0;
  logic [7:0]  buf_wdata_i = '0;
  logic [7:0]  buf_rdata_o;

  always #2.5 clk = ~clk;

  sector_dma dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .fill_i(fill_i), .den_i(den_i),
    .wc_i(wc_i), .addr_i(addr_i), .ext_i(ext_i), .busy_o(busy_o), .done_o(done_o),
    .err_code_o(err_code_o), .wco_o(wco_o), .nxm_o(nxm_o), .resid_o(resid_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_nxm_i(mem_nxm), .buf_we_i(buf_we_i), .buf_addr_i(buf_addr_i),
    .buf_wdata_i(buf_wdata_i), .buf_rdata_o(buf_rdata_o)
  );

  int checks = 0;
  int errors = 0;

  // ---------------- memory model ----------------
  logic [7:0]  wr_img [1024];
  logic        clr_req = 1'b0;
  logic [17:0] exp_base = '0;
  int          nxm_at = 1023;
  int          ack_lat = 0;
  int          cyc = 0;
  int          reqs = 0;
  int          addr_err = 0;
  int          stab_err = 0;
  int          first_req_cyc = -1;
  int          done_cnt = 0;
  int          wcnt = 0;
  logic [17:0] held_addr = '0;

  function automatic logic [7:0] mdata(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]};
  endfunction

  function automatic logic [7:0] pre(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done_o) done_cnt = done_cnt + 1;
    if (clr_req) begin
      reqs = 0; addr_err = 0; stab_err = 0; first_req_cyc = -1; done_cnt = 0; wcnt = 0;
    end
    mem_ack <= 1'b0;
    mem_nxm <= 1'b0;
    if (mem_req_o && !mem_ack) begin
      if (wcnt > 0 && mem_addr_o != held_addr) stab_err = stab_err + 1;
      held_addr = mem_addr_o;
      if (wcnt < ack_lat) begin
        wcnt = wcnt + 1;
      end else begin
        wcnt = 0;
        if (mem_addr_o != exp_base + 18'(reqs)) addr_err = addr_err + 1;
        if (reqs == 0) first_req_cyc = cyc;
        mem_ack   <= 1'b1;
        mem_nxm   <= (reqs == nxm_at);
        mem_rdata <= mdata(mem_addr_o);
        if (mem_we_o && reqs != nxm_at) wr_img[mem_addr_o[9:0]] <= mem_wdata_o;
        reqs = reqs + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buf_write(input int i, input logic [7:0] d);
    @(negedge clk);
    buf_addr_i = 8'(i); buf_wdata_i = d; buf_we_i = 1'b1;
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  task automatic buf_read(input int i, output logic [7:0] d);
    @(negedge clk);
    buf_addr_i = 8'(i);
    @(negedge clk);
    d = buf_rdata_o;
  endtask

  task automatic preload();
    for (int i = 0; i < 256; i++) buf_write(i, pre(i));
  endtask

  task automatic clear_stats();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  task automatic kick(input logic f, input logic d, input logic [7:0] w,
                      input logic [15:0] a, input logic [1:0] x, output int sc);
    @(negedge clk);
    fill_i = f; den_i = d; wc_i = w; addr_i = a; ext_i = x; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    sc = cyc;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done_o && t < 5000) begin @(negedge clk); t++; end
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        fill;
    logic        den;
    logic [7:0]  wc;
    logic [15:0] addr;
    logic [1:0]  ext;
    logic [9:0]  nxm_at;
    logic [7:0]  code;
    logic        wco;
    logic        nxm;
    logic [7:0]  resid;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd64,  16'h0010, 2'd0, 10'h3FF, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 1'b0, 8'd65,  16'h0010, 2'd0, 10'h3FF, 8'h98, 1'b1, 1'b0, 8'd65},
    '{1'b1, 1'b1, 8'd128, 16'h0200, 2'd2, 10'h3FF, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b0, 1'b1, 8'd129, 16'h0000, 2'd0, 10'h3FF, 8'h98, 1'b1, 1'b0, 8'd129},
    '{1'b0, 1'b0, 8'd10,  16'h0100, 2'd1, 10'd5,   8'h00, 1'b0, 1'b1, 8'd7},
    '{1'b1, 1'b0, 8'd4,   16'h0040, 2'd0, 10'd0,   8'h00, 1'b0, 1'b1, 8'd4},
    '{1'b0, 1'b0, 8'd0,   16'h0080, 2'd0, 10'h3FF, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 1'b0, 8'd3,   16'hFFFE, 2'd1, 10'h3FF, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 1'b1, 8'd0,   16'h0000, 2'd3, 10'h3FF, 8'h00, 1'b0, 1'b0, 8'd0}
  };

  task automatic run_vec(input vec_t v);
    int sc, len, lim, exp_reqs, ok_bytes, bad;
    bit ovf;
    logic [7:0] b, e;
    logic [17:0] base;
    base = {v.ext, v.addr};
    preload();
    exp_base = base;
    nxm_at = int'(v.nxm_at);
    clear_stats();
    kick(v.fill, v.den, v.wc, v.addr, v.ext, sc);
    wait_done();
    len = 2 * int'(v.wc);
    lim = v.den ? 256 : 128;
    ovf = len > lim;
    exp_reqs = ovf ? 0 : ((nxm_at < len) ? nxm_at + 1 : len);
    ok_bytes = ovf ? 0 : ((nxm_at < len) ? nxm_at : len);
    chk(done_o == 1'b1, "R8 done", done_o, 1);
    chk(err_code_o == v.code, "R2/R6/R7 code", err_code_o, v.code);
    chk(wco_o == v.wco, "R2 wco", wco_o, v.wco);
    chk(nxm_o == v.nxm, "R6 nxm", nxm_o, v.nxm);
    chk(resid_o == v.resid, "R6/R7 resid", resid_o, v.resid);
    chk(reqs == exp_reqs, "R1/R10 request count", reqs, exp_reqs);
    chk(addr_err == 0, "R4 address order", addr_err, 0);
    if (v.fill && exp_reqs > 0)
      chk(first_req_cyc - sc >= 256, "R3 clear before reads", first_req_cyc - sc, 256);
    bad = 0;
    if (v.fill) begin
      for (int i = 0; i < 256; i++) begin
        buf_read(i, b);
        e = ovf ? pre(i) : ((i < ok_bytes) ? mdata(base + 18'(i)) : 8'h00);
        if (b !== e) bad++;
      end
      chk(bad == 0, ovf ? "R2 buffer untouched" : "R3/R5 buffer content", bad, 0);
    end else begin
      for (int i = 0; i < ok_bytes; i++) begin
        logic [17:0] a;
        a = base + 18'(i);
        if (wr_img[a[9:0]] !== pre(i)) bad++;
      end
      chk(bad == 0, "R5 memory content", bad, 0);
    end
  endtask

  bit finished = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sc;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(busy_o == 0 && done_o == 0 && mem_req_o == 0, "R11 idle outputs",
        {busy_o, done_o, mem_req_o}, 0);
    chk(err_code_o == 0 && resid_o == 0 && wco_o == 0 && nxm_o == 0, "R11 status",
        {err_code_o, resid_o, wco_o, nxm_o}, 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8: start while busy ignored, single one-cycle done
    exp_base = 18'h00020; nxm_at = 1023;
    clear_stats();
    kick(1'b1, 1'b0, 8'd2, 16'h0020, 2'd0, sc);
    @(negedge clk);
    fill_i = 1'b0; wc_i = 8'd5; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    chk(busy_o == 1'b0, "R8 idle after done", busy_o, 0);
    repeat (300) @(negedge clk);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);
    chk(reqs == 4, "R8 busy start ignored", reqs, 4);

    // R9: buffer-port write ignored while busy
    preload();
    exp_base = 18'h00300; nxm_at = 1023;
    clear_stats();
    kick(1'b0, 1'b0, 8'd64, 16'h0300, 2'd0, sc);
    buf_write(200, 8'hEE);
    wait_done();
    buf_read(200, b);
    chk(b == pre(200), "R9 busy write ignored", b, pre(200));
    buf_write(7, 8'h3C);
    buf_read(7, b);
    chk(b == 8'h3C, "R9 idle write and read", b, 8'h3C);

    // R12: request held while acknowledge is delayed
    preload();
    ack_lat = 3;
    exp_base = 18'h00040; nxm_at = 1023;
    clear_stats();
    kick(1'b0, 1'b0, 8'd8, 16'h0040, 2'd0, sc);
    wait_done();
    chk(stab_err == 0, "R12 stable request", stab_err, 0);
    chk(reqs == 16 && addr_err == 0, "R12 slow memory count", reqs, 16);
    chk(err_code_o == 0 && nxm_o == 0, "R7 slow memory status", err_code_o, 0);
    ack_lat = 0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule